// File: doc/BRIEF.md
# Next-Cycle Implication Monitor with Activity Counters

This block watches two single-bit signals and checks the property that whenever the antecedent (`ante_i`) is sampled high, the consequent (`cons_i`) must be high on the following clock. It samples both inputs once per clock. It reports its verdict as a three-state machine: waiting for the antecedent, checking the consequent, or failed.

Alongside the verdict it keeps three saturating counters:

- non-vacuous satisfactions;
- antecedent firings;
- consequent satisfactions.

After a run, these counts let the property be scored by how much real activity it saw. A count-enable input leaves chosen cycles out of the statistics, such as warm-up cycles, without changing the checking itself. A failure is absorbing until reset. It raises a one-cycle pulse and a sticky flag.

Top module: `impl_monitor`

## Requirements
- R1: A synchronous active-high reset puts the state output at WAIT (encoding 0), clears all three counters, and clears the fail pulse and the sticky error flag.
- R2: In WAIT (0), a cycle with `ante_i` low leaves the state at WAIT.
- R3: In WAIT (0), a cycle with `ante_i` high moves the state to CHECK (encoding 1) at the next clock.
- R4: In CHECK (1), with `cons_i` high, the state stays in CHECK if `ante_i` is high and returns to WAIT if `ante_i` is low.
- R5: In CHECK (1), a cycle with `cons_i` low moves the state to FAIL (encoding 2). FAIL does not change until reset, whatever the inputs.
- R6: `fail_o` is high for exactly the one cycle in which the state first shows FAIL. `err_o` rises in that same cycle and stays high until reset.
- R7: The occurrence counter adds one for each cycle in CHECK with `cons_i` high.
- R8: The antecedent counter adds one for each cycle with `ante_i` high that is either in WAIT, or in CHECK with `cons_i` high.
- R9: The consequent counter adds one for each cycle in CHECK with `cons_i` high.
- R10: While `cnt_en_i` is low, no counter changes, but state, `fail_o` and `err_o` behave as with it high.
- R11: Each counter is `CNT_W` bits wide and holds at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Enables counter updates |
| ante_i | input | 1 | Antecedent sample |
| cons_i | input | 1 | Consequent sample |
| state_o | output | 2 | Monitor state: 0 WAIT, 1 CHECK, 2 FAIL |
| fail_o | output | 1 | One-cycle pulse on entering FAIL |
| err_o | output | 1 | Sticky error flag |
| cnt_occ_o | output | CNT_W | Non-vacuous satisfaction count |
| cnt_ante_o | output | CNT_W | Antecedent firing count |
| cnt_cons_o | output | CNT_W | Consequent satisfaction count |

## Verification
The bench sweeps every four-cycle sequence of (antecedent, consequent, enable) from reset, with a narrow counter width, and predicts each output arithmetically. This reaches the corner cases:

- A back-to-back antecedent while checking: a design that left CHECK there would miss the second obligation and undercount the antecedent.
- An antecedent with a low consequent: a design that counted this as an antecedent firing, or left FAIL when inputs changed, would show wrong counts or a wrong state.
- A disabled cycle that happens to fail: a gate applied to the verdict would hide the failure.
- A long satisfied run that drives the counters past all ones: a wrapping counter would fall back to zero.

// File: rtl/impl_monitor_pkg.sv
package impl_monitor_pkg;
  typedef enum logic [1:0] {
    MON_WAIT  = 2'd0,
    MON_CHECK = 2'd1,
    MON_FAIL  = 2'd2
  } mon_state_e;

  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned IDX_OCC  = 0;
  localparam int unsigned IDX_ANTE = 1;
  localparam int unsigned IDX_CONS = 2;
endpackage

// File: rtl/impl_monitor_fsm.sv
module impl_monitor_fsm
  import impl_monitor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ante_i,
  input  logic       cons_i,
  output mon_state_e state_o,
  output logic       ev_occ_o,
  output logic       ev_ante_o,
  output logic       ev_cons_o,
  output logic       enter_fail_o
);
  mon_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MON_WAIT:  state_d = ante_i ? MON_CHECK : MON_WAIT;
      MON_CHECK: begin
        if (!cons_i)     state_d = MON_FAIL;
        else if (ante_i) state_d = MON_CHECK;
        else             state_d = MON_WAIT;
      end
      MON_FAIL:  state_d = MON_FAIL;
      default:   state_d = MON_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MON_WAIT;
    else     state_q <= state_d;
  end

  // Transition-based events, evaluated on the current state and inputs
  always_comb begin
    ev_occ_o     = (state_q == MON_CHECK) && cons_i;
    ev_cons_o    = (state_q == MON_CHECK) && cons_i;
    ev_ante_o    = ante_i && ((state_q == MON_WAIT) ||
                              ((state_q == MON_CHECK) && cons_i));
    enter_fail_o = (state_q == MON_CHECK) && !cons_i;
  end

  assign state_o = state_q;

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == MON_WAIT && !ante_i) |=> (state_q == MON_WAIT)); // R2
  AST_ENTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    (state_q == MON_WAIT && ante_i) |=> (state_q == MON_CHECK)); // R3
  AST_FAIL_ABSORB: assert property (@(posedge clk) disable iff (rst)
    (state_q == MON_FAIL) |=> (state_q == MON_FAIL)); // R5
endmodule

// File: rtl/impl_sat_counter.sv
module impl_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             ev_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                             cnt_q <= '0;
    else if (en_i && ev_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R11
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_i) |=> $stable(cnt_q)); // R10
  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/impl_monitor.sv
module impl_monitor
  import impl_monitor_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  logic             ante_i,
  input  logic             cons_i,
  output logic [1:0]       state_o,
  output logic             fail_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_occ_o,
  output logic [CNT_W-1:0] cnt_ante_o,
  output logic [CNT_W-1:0] cnt_cons_o
);
  mon_state_e           state;
  logic                 ev_occ, ev_ante, ev_cons, enter_fail;
  logic [NUM_CNT-1:0]   ev_vec;
  logic [CNT_W-1:0]     cnt_arr [NUM_CNT];
  logic                 fail_q, err_q;

  impl_monitor_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ante_i       (ante_i),
    .cons_i       (cons_i),
    .state_o      (state),
    .ev_occ_o     (ev_occ),
    .ev_ante_o    (ev_ante),
    .ev_cons_o    (ev_cons),
    .enter_fail_o (enter_fail)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[IDX_OCC]  = ev_occ;
    ev_vec[IDX_ANTE] = ev_ante;
    ev_vec[IDX_CONS] = ev_cons;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    impl_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .en_i  (cnt_en_i),
      .ev_i  (ev_vec[g]),
      .cnt_o (cnt_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      fail_q <= enter_fail;
      err_q  <= err_q | enter_fail;
    end
  end

  assign state_o    = state;
  assign fail_o     = fail_q;
  assign err_o      = err_q;
  assign cnt_occ_o  = cnt_arr[IDX_OCC];
  assign cnt_ante_o = cnt_arr[IDX_ANTE];
  assign cnt_cons_o = cnt_arr[IDX_CONS];

  AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R6
  AST_FAIL_IN_FAIL: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (state_o == 2'd2)); // R5
endmodule

// File: tb/impl_monitor_bench.sv
module impl_monitor_bench;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en_i = 1'b0, ante_i = 1'b0, cons_i = 1'b0;
  logic [1:0] state_o;
  logic fail_o, err_o;
  logic [CNT_W-1:0] cnt_occ_o, cnt_ante_o, cnt_cons_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_state, m_occ, m_ante, m_cons;
  bit m_fail, m_err;

  always #2.5 clk = ~clk;

  impl_monitor #(.CNT_W(CNT_W)) u_impl_monitor (
    .clk(clk), .rst(rst), .cnt_en_i(cnt_en_i), .ante_i(ante_i), .cons_i(cons_i),
    .state_o(state_o), .fail_o(fail_o), .err_o(err_o),
    .cnt_occ_o(cnt_occ_o), .cnt_ante_o(cnt_ante_o), .cnt_cons_o(cnt_cons_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string st_tag(int ms, bit a, bit c);
    if (ms == 0) return a ? "R3 state" : "R2 state";
    if (ms == 1) return c ? "R4 state" : "R5 state";
    return "R5 absorb";
  endfunction

  task automatic compare_all(string st);
    chk(st, state_o, m_state);
    chk("R6 fail pulse", fail_o, m_fail);
    chk("R6 sticky err", err_o, m_err);
    chk("R7 occ count (R10 R11)", cnt_occ_o, m_occ);
    chk("R8 ante count (R10 R11)", cnt_ante_o, m_ante);
    chk("R9 cons count (R10 R11)", cnt_cons_o, m_cons);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ante_i = 1'b0; cons_i = 1'b0; cnt_en_i = 1'b0;
    @(posedge clk); #1;
    m_state = 0; m_occ = 0; m_ante = 0; m_cons = 0; m_fail = 0; m_err = 0;
    chk("R1 reset state", state_o, 0);
    chk("R1 reset occ", cnt_occ_o, 0);
    chk("R1 reset ante", cnt_ante_o, 0);
    chk("R1 reset cons", cnt_cons_o, 0);
    chk("R1 reset fail", fail_o, 0);
    chk("R1 reset err", err_o, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(bit a, bit c, bit e);
    string st;
    bit occ, ant, fl;
    @(negedge clk);
    ante_i = a; cons_i = c; cnt_en_i = e;
    @(posedge clk); #1;
    st  = st_tag(m_state, a, c);
    occ = (m_state == 1) && c;
    ant = a && ((m_state == 0) || ((m_state == 1) && c));
    fl  = (m_state == 1) && !c;
    if (e && occ && m_occ  < CMAX) m_occ++;
    if (e && occ && m_cons < CMAX) m_cons++;
    if (e && ant && m_ante < CMAX) m_ante++;
    m_fail = fl;
    m_err  = m_err | fl;
    if (m_state == 0)      m_state = a ? 1 : 0;
    else if (m_state == 1) m_state = !c ? 2 : (a ? 1 : 0);
    compare_all(st);
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Sweep every 4-cycle sequence of 3-bit inputs {ante, cons, en}
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int k = 0; k < 4; k++) begin
        int v = (s >> (3 * k)) & 7;
        step(v[2], v[1], v[0]);
      end
    end
    // R11: long satisfied run past counter maximum
    do_reset();
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1);
    chk("R11 occ saturated", cnt_occ_o, CMAX);
    chk("R11 ante saturated", cnt_ante_o, CMAX);
    // R10: disabled run, then fail while disabled
    do_reset();
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R10 counts frozen", cnt_ante_o, 0);
    chk("R5 fail while disabled", state_o, 2);
    for (int k = 0; k < 8; k++) step(k[0], k[1], 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule